// File: doc/BRIEF.md
# Decimal Arithmetic Opcode Sequencer

This block accepts one 16-bit opcode at a time and, when it names a packed-decimal add, subtract or negate, runs the operation to completion. Operands come either from an external 8×32 data register file or from a byte-wide memory port that uses a ready handshake. Memory operands are addressed through an external 8×32 address register file, with each register moved down by one byte before it is used. A two-digit decimal arithmetic unit, held as a submodule, does the computation. The block also produces the extend, carry and zero flag updates.

The register files and the flag bits live outside the block. The sequencer drives register indices, write enables and write data, and reads back the current contents combinationally. A new opcode is taken on `valid_i` while `busy_o` is low. Completion is signalled by a one-cycle `done_o`. Opcodes that are not supported return `illegal_o` and nothing else happens.

Top module: `bcd_seq`

## Requirements
- R1: An opcode is a decimal add when `opcode & 0xF1F8` is 0xC100 (register form) or 0xC108 (memory form). It is a decimal subtract when that value is 0x8100 or 0x8108. The source register number is in opcode bits 2:0 and the destination register number is in bits 11:9.
- R2: An opcode is a decimal negate when `opcode & 0xFFC0` is 0x4800, and bits 5:3 then select the mode. Mode 000 operates on data register bits 2:0. Mode 100 operates on predecremented memory through address register bits 2:0. Any other negate mode, or any opcode not listed, pulses `illegal_o` for one cycle. In that case no register, memory location or flag changes and `done_o` stays low.
- R3: The register form replaces only bits 7:0 of the destination data register and keeps bits 31:8. A register-form negate writes back the same register it read.
- R4: For decimal operands, add gives `(src + dst + X) mod 100` in packed decimal, with a carry when the sum is 100 or more.
- R5: For decimal operands, subtract gives `(dst - src - X) mod 100`, with a borrow when the difference is negative. Negate gives `(0 - operand - X) mod 100` with the same borrow rule.
- R6: On completion, X and C both take the carry or borrow. Z is cleared when the result byte is nonzero and is otherwise left at its previous value.
- R7: The memory form proceeds in this order:
  1. Decrement the source address register by 1.
  2. Load the byte at the new source address.
  3. Decrement the destination address register by 1.
  4. Load the byte at the new destination address.
  5. Store the result to that destination address.
- R8: When the source and destination address registers are the same, that register is decremented twice. The source byte is read at the original value minus 1, and the destination byte is read and written at the original value minus 2.
- R9: A memory-form negate decrements its address register by 1, loads the byte there and stores the result to the same address.
- R10: Each memory access holds its request, address and direction unchanged until `mem_rdy_i` is sampled high.
- R11: `done_o` is high for exactly one cycle, in the cycle after the data register writeback or the accepted store.
- R12: After reset the block is idle: `busy_o`, `done_o`, `illegal_o` and every request and write enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Opcode present; taken when idle |
| opcode_i | input | 16 | Instruction word |
| x_i | input | 1 | Current extend flag |
| z_i | input | 1 | Current zero flag |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle unsupported-opcode pulse |
| dr_src_idx_o | output | 3 | Data register source read index |
| dr_dst_idx_o | output | 3 | Data register destination read/write index |
| dr_src_data_i | input | 32 | Data register source contents |
| dr_dst_data_i | input | 32 | Data register destination contents |
| dr_we_o | output | 1 | Data register write enable (destination index) |
| dr_wdata_o | output | 32 | Data register write value |
| ar_idx_o | output | 3 | Address register read/write index |
| ar_rdata_i | input | 32 | Address register contents |
| ar_we_o | output | 1 | Address register write enable |
| ar_wdata_o | output | 32 | Address register write value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a store |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 8 | Store data |
| mem_rdata_i | input | 8 | Load data |
| mem_rdy_i | input | 1 | Memory access completes this cycle |
| flag_we_o | output | 1 | Flag update strobe |
| x_o | output | 1 | New extend flag |
| c_o | output | 1 | New carry flag |
| z_o | output | 1 | New zero flag |

## Verification
The assertions assume three things about the surrounding logic:
- Register read data reflects any write made on the previous edge.
- `mem_rdata_i` is valid whenever `mem_rdy_i` completes a load.
- `valid_i` is raised only while `busy_o` is low.

The bench meets these by modelling the register files and memory as arrays that update on the clock edge and read combinationally. It offers a new opcode only after seeing `done_o` or `illegal_o`. Memory ready is either held high or raised every third cycle, so that each wait state is exercised.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned REG_IDX_W = 3;

  typedef enum logic [1:0] {OP_ADD, OP_SUB, OP_NEG} bcd_op_e;

  typedef struct packed {
    logic                 legal;
    bcd_op_e              op;
    logic                 mem;
    logic [REG_IDX_W-1:0] src;
    logic [REG_IDX_W-1:0] dst;
  } bcd_dec_t;

  typedef enum logic [2:0] {
    S_IDLE, S_REG, S_SRC_DEC, S_SRC_LD, S_DST_DEC, S_DST_LD, S_STORE
  } bcd_state_e;
endpackage

// File: rtl/bcd_decode.sv
module bcd_decode
  import bcd_pkg::*;
#(
  parameter int unsigned OPW = 16
) (
  input  logic [OPW-1:0] opcode_i,
  output bcd_dec_t       dec_o
);
  localparam logic [OPW-1:0] PAIR_MASK = 16'hF1F8;
  localparam logic [OPW-1:0] NEG_MASK  = 16'hFFC0;

  logic [OPW-1:0] pair_bits;
  logic [2:0]     neg_mode;

  assign pair_bits = opcode_i & PAIR_MASK;
  assign neg_mode  = opcode_i[5:3];

  always_comb begin
    dec_o       = '0;
    dec_o.op    = OP_ADD;
    dec_o.src   = opcode_i[2:0];
    dec_o.dst   = opcode_i[11:9];
    dec_o.mem   = opcode_i[3];
    if (pair_bits == 16'hC100 || pair_bits == 16'hC108) begin
      dec_o.legal = 1'b1;
      dec_o.op    = OP_ADD;
    end else if (pair_bits == 16'h8100 || pair_bits == 16'h8108) begin
      dec_o.legal = 1'b1;
      dec_o.op    = OP_SUB;
    end else if ((opcode_i & NEG_MASK) == 16'h4800) begin
      dec_o.op  = OP_NEG;
      dec_o.dst = opcode_i[2:0];
      dec_o.mem = (neg_mode == 3'b100);
      dec_o.legal = (neg_mode == 3'b000) || (neg_mode == 3'b100);
    end
  end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu #(
  parameter int unsigned BW = 8
) (
  input  logic          sub_i,
  input  logic [BW-1:0] src_i,
  input  logic [BW-1:0] dst_i,
  input  logic          x_i,
  output logic [BW-1:0] res_o,
  output logic          carry_o
);
  // two packed digits; wide intermediate keeps borrows visible
  localparam int unsigned IW = BW + 4;

  logic [IW-1:0] lo, hi, r, diff, diff_adj;
  logic [IW-1:0] sx, dx, xx;
  logic          lo_borrow;

  assign sx = IW'(src_i);
  assign dx = IW'(dst_i);
  assign xx = IW'(x_i);

  always_comb begin
    carry_o   = 1'b0;
    lo_borrow = 1'b0;
    diff      = '0;
    diff_adj  = '0;
    if (!sub_i) begin
      lo = (sx & 'hF) + (dx & 'hF) + xx;
      hi = (sx & 'hF0) + (dx & 'hF0);
      r  = hi + lo;
      if (lo > 'd9) r = r + 'h6;
      if ((r & 'h3F0) > 'h90) begin
        r       = r + 'h60;
        carry_o = 1'b1;
      end
    end else begin
      lo = (dx & 'hF) - (sx & 'hF) - xx;
      hi = (dx & 'hF0) - (sx & 'hF0);
      r  = hi + lo;
      lo_borrow = |(lo & 'hF0);
      if (lo_borrow) r = r - 'h6;
      diff = dx - sx - xx;
      if (diff[8]) r = r - 'h60;
      diff_adj = diff - (lo_borrow ? IW'(6) : IW'(0));
      carry_o  = |diff_adj[9:8];
    end
    res_o = r[BW-1:0];
  end
endmodule

// File: rtl/bcd_seq.sv
module bcd_seq
  import bcd_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned OPW = 16,
  parameter int unsigned BW  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [OPW-1:0]       opcode_i,
  input  logic                 x_i,
  input  logic                 z_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 illegal_o,
  output logic [REG_IDX_W-1:0] dr_src_idx_o,
  output logic [REG_IDX_W-1:0] dr_dst_idx_o,
  input  logic [DW-1:0]        dr_src_data_i,
  input  logic [DW-1:0]        dr_dst_data_i,
  output logic                 dr_we_o,
  output logic [DW-1:0]        dr_wdata_o,
  output logic [REG_IDX_W-1:0] ar_idx_o,
  input  logic [DW-1:0]        ar_rdata_i,
  output logic                 ar_we_o,
  output logic [DW-1:0]        ar_wdata_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic [DW-1:0]        mem_addr_o,
  output logic [BW-1:0]        mem_wdata_o,
  input  logic [BW-1:0]        mem_rdata_i,
  input  logic                 mem_rdy_i,
  output logic                 flag_we_o,
  output logic                 x_o,
  output logic                 c_o,
  output logic                 z_o
);
  localparam logic [DW-1:0] STEP = DW'(1);

  bcd_state_e state_q;
  bcd_dec_t   dec, dec_q;
  logic [BW-1:0] src_q, dst_q, alu_a, alu_b, alu_res;
  logic [DW-1:0] addr_q, ar_dec;
  logic          alu_carry, done_q, illegal_q, store_ok;

  bcd_decode #(.OPW(OPW)) u_decode (
    .opcode_i (opcode_i),
    .dec_o    (dec)
  );

  always_comb begin
    if (state_q == S_REG) begin
      alu_a = (dec_q.op == OP_NEG) ? dr_dst_data_i[BW-1:0] : dr_src_data_i[BW-1:0];
      alu_b = (dec_q.op == OP_NEG) ? '0 : dr_dst_data_i[BW-1:0];
    end else begin
      alu_a = src_q;
      alu_b = dst_q;
    end
  end

  bcd_alu #(.BW(BW)) u_alu (
    .sub_i   (dec_q.op != OP_ADD),
    .src_i   (alu_a),
    .dst_i   (alu_b),
    .x_i     (x_i),
    .res_o   (alu_res),
    .carry_o (alu_carry)
  );

  assign ar_dec       = ar_rdata_i - STEP;
  assign store_ok     = (state_q == S_STORE) && mem_rdy_i;
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = done_q;
  assign illegal_o    = illegal_q;
  assign dr_src_idx_o = dec_q.src;
  assign dr_dst_idx_o = dec_q.dst;
  assign dr_we_o      = (state_q == S_REG);
  assign dr_wdata_o   = {dr_dst_data_i[DW-1:BW], alu_res};
  // negate memory form keeps its register number in dst
  assign ar_idx_o     = (state_q == S_DST_DEC || dec_q.op == OP_NEG) ? dec_q.dst : dec_q.src;
  assign ar_we_o      = (state_q == S_SRC_DEC) || (state_q == S_DST_DEC);
  assign ar_wdata_o   = ar_dec;
  assign mem_req_o    = (state_q == S_SRC_LD) || (state_q == S_DST_LD) || (state_q == S_STORE);
  assign mem_we_o     = (state_q == S_STORE);
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = alu_res;
  assign flag_we_o    = dr_we_o || store_ok;
  assign x_o          = alu_carry;
  assign c_o          = alu_carry;
  assign z_o          = z_i && (alu_res == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      dec_q     <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      addr_q    <= '0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (valid_i) begin
          dec_q <= dec;
          dst_q <= '0;
          if (!dec.legal)   illegal_q <= 1'b1;
          else if (dec.mem) state_q   <= S_SRC_DEC;
          else              state_q   <= S_REG;
        end
        S_REG: begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        S_SRC_DEC: begin
          addr_q  <= ar_dec;
          state_q <= S_SRC_LD;
        end
        S_SRC_LD: if (mem_rdy_i) begin
          src_q   <= mem_rdata_i;
          state_q <= (dec_q.op == OP_NEG) ? S_STORE : S_DST_DEC;
        end
        S_DST_DEC: begin
          addr_q  <= ar_dec;
          state_q <= S_DST_LD;
        end
        S_DST_LD: if (mem_rdy_i) begin
          dst_q   <= mem_rdata_i;
          state_q <= S_STORE;
        end
        S_STORE: if (mem_rdy_i) begin
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_done_follows_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |=> done_o);
  assert_done_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_req_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  assert_one_access_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dr_we_o, ar_we_o, mem_req_o}));
  assert_illegal_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !(dr_we_o || ar_we_o || mem_req_o || flag_we_o || done_o || busy_o));
  assert_store_after_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !$past(mem_we_o)) |-> $past(mem_req_o && !mem_we_o));
endmodule

// File: tb/bcd_seq_bench.sv
`timescale 1ns/1ps
module bcd_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] opcode_i = '0;
  logic        xf = 1'b0, zf = 1'b0;
  logic        busy_o, done_o, illegal_o;
  logic [2:0]  dr_src_idx_o, dr_dst_idx_o, ar_idx_o;
  logic [31:0] dr_src_data_i, dr_dst_data_i, dr_wdata_o, ar_rdata_i, ar_wdata_o, mem_addr_o;
  logic        dr_we_o, ar_we_o, mem_req_o, mem_we_o, flag_we_o, x_o, c_o, z_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic        mem_rdy_i = 1'b1;
  logic        slow = 1'b0;
  int unsigned rcnt = 0;
  int          n_chk = 0, n_fail = 0;
  int          cyc = 0;

  logic [31:0] dregs [8];
  logic [31:0] aregs [8];
  logic [7:0]  mem   [256];

  always #10 clk_i = ~clk_i;

  bcd_seq u_bcd_seq (
    .clk_i, .rst_ni, .valid_i, .opcode_i, .x_i(xf), .z_i(zf),
    .busy_o, .done_o, .illegal_o,
    .dr_src_idx_o, .dr_dst_idx_o, .dr_src_data_i, .dr_dst_data_i, .dr_we_o, .dr_wdata_o,
    .ar_idx_o, .ar_rdata_i, .ar_we_o, .ar_wdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_rdy_i,
    .flag_we_o, .x_o, .c_o, .z_o
  );

  assign dr_src_data_i = dregs[dr_src_idx_o];
  assign dr_dst_data_i = dregs[dr_dst_idx_o];
  assign ar_rdata_i    = aregs[ar_idx_o];
  assign mem_rdata_i   = mem[mem_addr_o[7:0]];

  always @(posedge clk_i) begin
    if (dr_we_o) dregs[dr_dst_idx_o] <= dr_wdata_o;
    if (ar_we_o) aregs[ar_idx_o] <= ar_wdata_o;
    if (mem_req_o && mem_we_o && mem_rdy_i) mem[mem_addr_o[7:0]] <= mem_wdata_o;
    if (flag_we_o) begin xf <= x_o; zf <= z_o; end
    cyc <= cyc + 1;
  end

  always @(negedge clk_i) begin
    rcnt <= rcnt + 1;
    mem_rdy_i <= slow ? (rcnt % 3 == 0) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] to_bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  task automatic run_op(input logic [15:0] op, output bit saw_done, output bit saw_ill);
    @(negedge clk_i);
    valid_i = 1'b1; opcode_i = op;
    @(negedge clk_i);
    valid_i = 1'b0;
    saw_done = 0; saw_ill = 0;
    for (int k = 0; k < 80; k++) begin
      if (done_o) begin saw_done = 1; break; end
      if (illegal_o) begin saw_ill = 1; break; end
      @(negedge clk_i);
    end
  endtask

  initial begin
    bit d, il;
    for (int i = 0; i < 8; i++) begin dregs[i] = 32'h0; aregs[i] = 32'h0; end
    for (int i = 0; i < 256; i++) mem[i] = 8'h0;
    #35;
    // R12 reset state
    chk(!busy_o && !done_o && !illegal_o, "R12 idle", {29'b0, busy_o, done_o, illegal_o}, 0);
    chk(!mem_req_o && !dr_we_o && !ar_we_o && !flag_we_o, "R12 quiet",
        {28'b0, mem_req_o, dr_we_o, ar_we_o, flag_we_o}, 0);
    rst_ni = 1'b1;

    // R1 R3 R4 R6: register-form add sweep
    for (int s = 0; s < 100; s++) begin
      for (int t = 0; t < 100; t++) begin
        int x, z, sum;
        x = (s + t) & 1; z = (s >> 1) & 1;
        @(negedge clk_i);
        dregs[5] = {24'hA5C3_1E, to_bcd(s)};
        dregs[3] = {24'h5A_3C_E1, to_bcd(t)};
        xf = 1'(x); zf = 1'(z);
        run_op(16'hC100 | (16'd3 << 9) | 16'd5, d, il);
        sum = s + t + x;
        chk(d, "R1 add done", {31'b0, d}, 1);
        chk(dregs[3] == {24'h5A3CE1, to_bcd(sum % 100)}, "R4 add result", dregs[3],
            {24'h5A3CE1, to_bcd(sum % 100)});
        chk(xf == (sum >= 100), "R6 add X", {31'b0, xf}, {31'b0, sum >= 100});
        chk(zf == (z == 1 && sum % 100 == 0), "R6 add Z", {31'b0, zf}, {31'b0, z == 1 && sum % 100 == 0});
        chk(dregs[5][7:0] == to_bcd(s), "R3 src kept", dregs[5], {24'h0, to_bcd(s)});
      end
    end

    // R1 R5 R6: register-form subtract sweep
    for (int s = 0; s < 100; s++) begin
      for (int t = 0; t < 100; t++) begin
        int x, z, dif;
        x = (s ^ t) & 1; z = 1;
        @(negedge clk_i);
        dregs[2] = {24'h0, to_bcd(s)};
        dregs[6] = {24'hFFFF00, to_bcd(t)};
        xf = 1'(x); zf = 1'(z);
        run_op(16'h8100 | (16'd6 << 9) | 16'd2, d, il);
        dif = t - s - x;
        chk(dregs[6] == {24'hFFFF00, to_bcd((dif + 200) % 100)}, "R5 sub result", dregs[6],
            {24'hFFFF00, to_bcd((dif + 200) % 100)});
        chk(xf == (dif < 0), "R6 sub X", {31'b0, xf}, {31'b0, dif < 0});
        chk(zf == ((dif + 200) % 100 == 0), "R6 sub Z", {31'b0, zf}, {31'b0, (dif + 200) % 100 == 0});
      end
    end

    // R2 R3 R5 R11: register-form negate
    for (int v = 0; v < 100; v++) begin
      for (int x = 0; x < 2; x++) begin
        int r;
        @(negedge clk_i);
        dregs[4] = {24'h123456, to_bcd(v)};
        xf = 1'(x); zf = 1'b1;
        run_op(16'h4800 | 16'd4, d, il);
        r = 0 - v - x;
        chk(dregs[4] == {24'h123456, to_bcd((r + 200) % 100)}, "R5 neg reg", dregs[4],
            {24'h123456, to_bcd((r + 200) % 100)});
        chk(xf == (r < 0), "R6 neg X", {31'b0, xf}, {31'b0, r < 0});
        @(negedge clk_i);
        chk(!done_o, "R11 single done", {31'b0, done_o}, 0);
      end
    end

    // R7 R10: memory form add/sub with slow ready
    slow = 1'b1;
    for (int i = 0; i < 120; i++) begin
      int s, t, x, r;
      bit is_sub;
      s = (i * 37) % 100; t = (i * 53 + 11) % 100; x = i & 1; is_sub = i[1];
      @(negedge clk_i);
      aregs[1] = 32'h0000_0041; aregs[4] = 32'h0000_00C1;
      mem[8'h40] = to_bcd(s); mem[8'hC0] = to_bcd(t);
      xf = 1'(x); zf = 1'b1;
      run_op((is_sub ? 16'h8108 : 16'hC108) | (16'd4 << 9) | 16'd1, d, il);
      r = is_sub ? (t - s - x) : (s + t + x);
      chk(d, "R10 mem done", {31'b0, d}, 1);
      chk(mem[8'hC0] == to_bcd((r + 200) % 100), "R7 mem result", {24'h0, mem[8'hC0]},
          {24'h0, to_bcd((r + 200) % 100)});
      chk(aregs[1] == 32'h40 && aregs[4] == 32'hC0, "R7 predecrement", aregs[4], 32'hC0);
      chk(mem[8'h40] == to_bcd(s), "R7 src untouched", {24'h0, mem[8'h40]}, {24'h0, to_bcd(s)});
      chk(xf == (is_sub ? r < 0 : r >= 100), "R6 mem X", {31'b0, xf}, {31'b0, is_sub ? r < 0 : r >= 100});
    end

    // R8: same address register for both operands
    for (int i = 0; i < 20; i++) begin
      int s, t;
      s = (i * 7) % 100; t = (i * 13 + 5) % 100;
      @(negedge clk_i);
      aregs[3] = 32'h20;
      mem[8'h1F] = to_bcd(s); mem[8'h1E] = to_bcd(t);
      xf = 1'b0; zf = 1'b1;
      run_op(16'hC108 | (16'd3 << 9) | 16'd3, d, il);
      chk(aregs[3] == 32'h1E, "R8 double dec", aregs[3], 32'h1E);
      chk(mem[8'h1E] == to_bcd((s + t) % 100), "R8 result", {24'h0, mem[8'h1E]}, {24'h0, to_bcd((s + t) % 100)});
      chk(mem[8'h1F] == to_bcd(s), "R8 src kept", {24'h0, mem[8'h1F]}, {24'h0, to_bcd(s)});
    end

    // R9: memory-form negate
    for (int v = 0; v < 30; v++) begin
      int r;
      @(negedge clk_i);
      aregs[6] = 32'h60; mem[8'h5F] = to_bcd(v); mem[8'h5E] = 8'h77;
      xf = v[0]; zf = 1'b1;
      r = 0 - v - v[0];
      run_op(16'h4820 | 16'd6, d, il);
      chk(aregs[6] == 32'h5F, "R9 dec", aregs[6], 32'h5F);
      chk(mem[8'h5F] == to_bcd((r + 200) % 100), "R9 result", {24'h0, mem[8'h5F]}, {24'h0, to_bcd((r + 200) % 100)});
      chk(mem[8'h5E] == 8'h77, "R9 neighbour", {24'h0, mem[8'h5E]}, 32'h77);
      chk(zf == ((r + 200) % 100 == 0), "R6 neg Z", {31'b0, zf}, {31'b0, (r + 200) % 100 == 0});
    end
    slow = 1'b0;

    // R2: unsupported encodings
    begin
      logic [15:0] bad [4];
      bad[0] = 16'h4808; bad[1] = 16'h4838; bad[2] = 16'h0000; bad[3] = 16'hC180;
      for (int i = 0; i < 4; i++) begin
        logic [31:0] d0, a0;
        logic [7:0] m0;
        @(negedge clk_i);
        dregs[0] = 32'h0000_0042; aregs[0] = 32'h0000_0090; mem[8'h8F] = 8'h55;
        xf = 1'b1; zf = 1'b1;
        d0 = dregs[0]; a0 = aregs[0]; m0 = mem[8'h8F];
        run_op(bad[i], d, il);
        chk(il && !d, "R2 illegal flagged", {30'b0, il, d}, 32'h2);
        chk(dregs[0] == d0 && aregs[0] == a0 && mem[8'h8F] == m0, "R2 no state change", dregs[0], d0);
        chk(xf && zf, "R2 flags kept", {30'b0, xf, zf}, 32'h3);
        @(negedge clk_i);
        chk(!illegal_o && !busy_o, "R2 illegal single", {30'b0, illegal_o, busy_o}, 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected below 190000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule